// File: doc/BRIEF.md
# Product-Term Cell Group with Shared Inverting Expanders

This block is one group of programmable logic cells. Each cell owns eight product terms: three that are ORed together, one that sets the output polarity through an XOR, and four secondary terms for set, clear, clock enable and output enable. The group also holds a pool of expander terms. Each expander is a programmable AND whose complemented output is offered to every product term in the group, including the terms of higher-numbered expanders. A wide function can therefore be built inside one cell without spending more cells. One expander can serve many cells, or several terms of the same cell, at the same time.

Every term selects from a single signal vector. The vector holds the dedicated inputs, the interconnect inputs, the register outputs of all cells, the registered pad levels and the expander outputs. Each cell drives one pad through an enable. A cell register stays internal when its pad is used as an input. The configuration is written one term word at a time. A write that would let an expander read itself or a higher-numbered expander is refused and flagged.

Top module: `expander_logic_block`

## Requirements
- R1: Signal vector order, from index 0: dedicated inputs, interconnect inputs, cell register outputs, registered pad levels, expander outputs. A term word holds bit 2k to require signal k high and bit 2k+1 to require it low. The term is the AND of the selected literals. An all-zero word, or a word that selects both polarities of one signal, gives a false term.
- R2: Expander e, at configuration address e, outputs the complement of its AND term. That output can be used by any term of any cell, and one expander can serve several cells at once.
- R3: Expander e may use only expanders below e. A write to expander address e that selects expander j with j >= e is discarded, and the error flag then rises and stays high until reset.
- R4: Cell c uses addresses NUM_EXP + 8c + s, with s = 0..2 for the OR terms, 3 for polarity, 4 for set, 5 for clear, 6 for clock enable and 7 for output enable. The cell value is (s0 | s1 | s2) XOR s3. In combinational mode, the pad output follows that value in the same cycle.
- R5: The cell register loads the cell value on the clock edge when the enable term is true or empty. It holds its value when the enable term is false.
- R6: Set and clear act synchronously. Clear forces 0 and wins over set. Set forces 1.
- R7: The pad enable equals the cell's output-enable term. An empty enable term leaves the pad undriven.
- R8: The pad level seen by the terms is registered. One cycle after an edge it equals the cell output if the pad is driven, otherwise the external pad input.
- R9: Cell feedback is always the register output, in both modes. A pad that is not driven can therefore act as an input while its register is used internally.
- R10: While reset is applied, all term words, mode bits, registers and the error flag are cleared, so every pad is undriven and outputs 0. Reset is removed two clock edges after the reset input rises.
- R11: Address NUM_EXP + 8*NUM_MC writes the mode word, where bit c = 1 makes cell c combinational. Writes to higher addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_i | input | NUM_DED | Dedicated inputs |
| ic_i | input | NUM_IC | Signals from the global interconnect |
| pad_i | input | NUM_MC | External level at each pad |
| pad_o | output | NUM_MC | Value each cell drives toward its pad |
| pad_oe | output | NUM_MC | Pad drive enable per cell |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Term, or mode word, address |
| cfg_data | input | 2*NSIG | Literal selection word |
| cfg_err | output | 1 | Sticky flag for a refused expander-loop write |

## Verification
The assertions check the register rules on every cycle: clear beats set, set gives 1, the enable either loads the cell value or holds, and an undriven pad is captured one cycle later. They also check that a refused expander write leaves the stored term unchanged and that the error flag stays high. Only the bench scenarios show the following: the logical function of the term literals, one expander shared by two cells, an expander feeding another expander, a register used internally while its pad is an input, and a toggle flip-flop built from the polarity term and the cell's own feedback.

// File: rtl/lab_pkg.sv
package lab_pkg;
  localparam int SLOTS     = 8;
  localparam int SLOT_SUM0 = 0;
  localparam int SLOT_SUM2 = 2;
  localparam int SLOT_POL  = 3;
  localparam int SLOT_SET  = 4;
  localparam int SLOT_CLR  = 5;
  localparam int SLOT_CE   = 6;
  localparam int SLOT_OE   = 7;

  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_COMB = 1'b1
  } cell_mode_e;
endpackage

// File: rtl/lab_pterm.sv
module lab_pterm #(
  parameter int NSIG = 8
) (
  input  logic [2*NSIG-1:0] mask,
  input  logic [NSIG-1:0]   sig,
  output logic              hit
);
  // AND of selected literals; an empty selection yields false
  always_comb begin
    hit = |mask;
    for (int k = 0; k < NSIG; k++) begin
      if (mask[2*k] && !sig[k])   hit = 1'b0;
      if (mask[2*k+1] && sig[k])  hit = 1'b0;
    end
  end
endmodule

// File: rtl/lab_cfg_store.sv
module lab_cfg_store #(
  parameter int NSIG     = 80,
  parameter int NUM_EXP  = 32,
  parameter int EXP_BASE = 48,
  parameter int NUM_MC   = 16,
  parameter int NUM_TRM  = 160,
  parameter int AW       = 8,
  localparam int MW      = 2*NSIG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [MW-1:0] data,
  output logic [MW-1:0] term_q [NUM_TRM],
  output logic [NUM_MC-1:0] mode_q,
  output logic          err_q
);
  logic bad;
  logic wr_term;
  logic wr_mode;
  logic err_nxt;

  // next-state: loop screen on expander words
  always_comb begin
    bad = 1'b0;
    if (int'(addr) < NUM_EXP) begin
      for (int j = 0; j < NUM_EXP; j++) begin
        if (j >= int'(addr) && (data[2*(EXP_BASE+j)] || data[2*(EXP_BASE+j)+1]))
          bad = 1'b1;
      end
    end
    wr_term = we && !bad && (int'(addr) < NUM_TRM);
    wr_mode = we && (int'(addr) == NUM_TRM);
    err_nxt = err_q || (we && bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TRM; t++) term_q[t] <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_term) term_q[addr] <= data;
      if (wr_mode) mode_q <= data[NUM_MC-1:0];
      err_q <= err_nxt;
    end
  end

  // R3: flag never drops without reset
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R3: refused write raises the flag
  a_r3_err_on_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bad) |=> err_q);
  // R3: refused write leaves the stored word alone
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bad) |=> (term_q[$past(addr)] == $past(term_q[addr])));
endmodule

// File: rtl/lab_expanders.sv
module lab_expanders #(
  parameter int NSIG     = 80,
  parameter int NUM_EXP  = 32,
  parameter int EXP_BASE = 48,
  localparam int MW      = 2*NSIG
) (
  input  logic [EXP_BASE-1:0] base_sig,
  input  logic [MW-1:0]       masks [NUM_EXP],
  output logic [NUM_EXP-1:0]  exp_o
);
  // ordered chain: stage i sees only expanders below i
  for (genvar i = 0; i < NUM_EXP; i++) begin : g_x
    logic [NUM_EXP-1:0] prev;
    logic [NUM_EXP-1:0] chain;
    logic               hit;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = g_x[i-1].chain;
    end
    lab_pterm #(.NSIG(NSIG)) u_term (
      .mask (masks[i]),
      .sig  ({prev, base_sig}),
      .hit  (hit)
    );
    always_comb begin
      chain    = prev;
      chain[i] = ~hit;
    end
  end

  assign exp_o = g_x[NUM_EXP-1].chain;
endmodule

// File: rtl/lab_macrocell.sv
module lab_macrocell
  import lab_pkg::*;
#(
  parameter int NSIG = 80,
  localparam int MW  = 2*NSIG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] sig,
  input  logic [MW-1:0]   masks [SLOTS],
  input  cell_mode_e      mode,
  output logic            q,
  output logic            pad_o,
  output logic            pad_oe
);
  logic [SLOTS-1:0] hits;
  logic sum;
  logic d;
  logic ce;
  logic clr;
  logic set;
  logic q_nxt;

  for (genvar s = 0; s < SLOTS; s++) begin : g_t
    lab_pterm #(.NSIG(NSIG)) u_term (
      .mask (masks[s]),
      .sig  (sig),
      .hit  (hits[s])
    );
  end

  always_comb begin
    sum    = |hits[SLOT_SUM2:SLOT_SUM0];
    d      = sum ^ hits[SLOT_POL];
    clr    = hits[SLOT_CLR];
    set    = hits[SLOT_SET];
    ce     = hits[SLOT_CE] | ~(|masks[SLOT_CE]);
    pad_oe = hits[SLOT_OE];
    pad_o  = (mode == MODE_COMB) ? d : q;
  end

  always_comb begin
    if (clr)      q_nxt = 1'b0;
    else if (set) q_nxt = 1'b1;
    else if (ce)  q_nxt = d;
    else          q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);
  a_r6_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> q);
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !clr && !set) |=> (q == $past(d)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !clr && !set) |=> $stable(q));
endmodule

// File: rtl/expander_logic_block.sv
module expander_logic_block
  import lab_pkg::*;
#(
  parameter int NUM_MC  = 16,
  parameter int NUM_EXP = 32,
  parameter int NUM_DED = 8,
  parameter int NUM_IC  = 8,
  localparam int EXP_BASE = NUM_DED + NUM_IC + 2*NUM_MC,
  localparam int NSIG     = EXP_BASE + NUM_EXP,
  localparam int MW       = 2*NSIG,
  localparam int NUM_TRM  = NUM_EXP + SLOTS*NUM_MC,
  localparam int CFG_AW   = $clog2(NUM_TRM + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DED-1:0] ded_i,
  input  logic [NUM_IC-1:0]  ic_i,
  input  logic [NUM_MC-1:0]  pad_i,
  output logic [NUM_MC-1:0]  pad_o,
  output logic [NUM_MC-1:0]  pad_oe,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [MW-1:0]      cfg_data,
  output logic               cfg_err
);
  logic [1:0]          rst_sync;
  logic                rst_int_n;
  logic [MW-1:0]       term_q [NUM_TRM];
  logic [MW-1:0]       exp_masks [NUM_EXP];
  logic [NUM_MC-1:0]   mode_q;
  logic [NUM_MC-1:0]   mc_q;
  logic [NUM_MC-1:0]   pin_fb_q;
  logic [NUM_MC-1:0]   pin_lvl;
  logic [EXP_BASE-1:0] base_sig;
  logic [NUM_EXP-1:0]  exp_v;
  logic [NSIG-1:0]     all_sig;

  // reset: asserted at once, removed on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lab_cfg_store #(
    .NSIG(NSIG), .NUM_EXP(NUM_EXP), .EXP_BASE(EXP_BASE),
    .NUM_MC(NUM_MC), .NUM_TRM(NUM_TRM), .AW(CFG_AW)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .data   (cfg_data),
    .term_q (term_q),
    .mode_q (mode_q),
    .err_q  (cfg_err)
  );

  always_comb begin
    pin_lvl  = (pad_oe & pad_o) | (~pad_oe & pad_i);
    base_sig = {pin_fb_q, mc_q, ic_i, ded_i};
    all_sig  = {exp_v, base_sig};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pin_fb_q <= '0;
    else            pin_fb_q <= pin_lvl;
  end

  for (genvar e = 0; e < NUM_EXP; e++) begin : g_em
    assign exp_masks[e] = term_q[e];
  end

  lab_expanders #(
    .NSIG(NSIG), .NUM_EXP(NUM_EXP), .EXP_BASE(EXP_BASE)
  ) u_exp (
    .base_sig (base_sig),
    .masks    (exp_masks),
    .exp_o    (exp_v)
  );

  for (genvar c = 0; c < NUM_MC; c++) begin : g_mc
    logic [MW-1:0] cm [SLOTS];
    cell_mode_e    cmode;
    for (genvar s = 0; s < SLOTS; s++) begin : g_s
      assign cm[s] = term_q[NUM_EXP + c*SLOTS + s];
    end
    assign cmode = cell_mode_e'(mode_q[c]);
    lab_macrocell #(.NSIG(NSIG)) u_mc (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .sig    (all_sig),
      .masks  (cm),
      .mode   (cmode),
      .q      (mc_q[c]),
      .pad_o  (pad_o[c]),
      .pad_oe (pad_oe[c])
    );
  end

  // R8: undriven pads reach the terms one cycle later
  a_r8_pad_capture: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pad_oe == '0) |=> (pin_fb_q == $past(pad_i)));
  // R10: while reset is held nothing is driven
  a_r10_quiet_reset: assert property (@(posedge clk)
    !rst_int_n |-> (pad_oe == '0 && !cfg_err));
endmodule

// File: tb/test_expander_logic_block.sv
module test_expander_logic_block;
  localparam int NUM_MC = 16, NUM_EXP = 32, NUM_DED = 8, NUM_IC = 8;
  localparam int S_DED = 0;
  localparam int S_IC  = NUM_DED;
  localparam int S_MC  = S_IC + NUM_IC;
  localparam int S_PIN = S_MC + NUM_MC;
  localparam int S_EXP = S_PIN + NUM_MC;
  localparam int NSIG  = S_EXP + NUM_EXP;
  localparam int MW    = 2*NSIG;
  localparam int NTRM  = NUM_EXP + 8*NUM_MC;
  localparam int AW    = $clog2(NTRM + 1);

  // {ded[3:0], ic[0], expected pad_o[1:0]}
  localparam logic [6:0] VEC [8] = '{
    7'b0000_0_11, 7'b0100_1_00, 7'b0111_1_01, 7'b1111_1_00,
    7'b1100_1_01, 7'b1000_0_10, 7'b0101_1_00, 7'b0110_1_00
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [NUM_DED-1:0] ded_i;
  logic [NUM_IC-1:0]  ic_i;
  logic [NUM_MC-1:0]  pad_i;
  logic [NUM_MC-1:0]  pad_o;
  logic [NUM_MC-1:0]  pad_oe;
  logic               cfg_we;
  logic [AW-1:0]      cfg_addr;
  logic [MW-1:0]      cfg_data;
  logic               cfg_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  expander_logic_block #(.NUM_MC(NUM_MC), .NUM_EXP(NUM_EXP),
    .NUM_DED(NUM_DED), .NUM_IC(NUM_IC)) i_expander_logic_block (
    .clk(clk), .rst_n(rst_n), .ded_i(ded_i), .ic_i(ic_i), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_err(cfg_err));

  function automatic logic [MW-1:0] lit(int s, bit low);
    logic [MW-1:0] m = '0;
    m[2*s + int'(low)] = 1'b1;
    return m;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int a, logic [MW-1:0] d);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_data = d;
    tick();
    cfg_we = 1'b0; cfg_data = '0;
  endtask

  function automatic int ca(int c, int s);
    return NUM_EXP + 8*c + s;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ded_i = '0; ic_i = '0; pad_i = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    tick(); tick();
    chk("R10 reset pad_oe", 32'(pad_oe), 0);
    chk("R10 reset pad_o", 32'(pad_o), 0);
    chk("R10 reset cfg_err", 32'(cfg_err), 0);
    rst_n = 1'b1;
    tick(); tick(); tick();

    // configuration
    wr(0, lit(S_DED+2,0) | lit(S_IC+0,0));           // exp0 = ~(d2&i0)
    wr(1, lit(S_EXP+0,0) | lit(S_DED+4,0));          // exp1 = ~(exp0&d4)
    wr(ca(0,0), lit(S_DED+0,0) | lit(S_DED+1,0));
    wr(ca(0,1), lit(S_EXP+0,0));
    wr(ca(0,3), lit(S_DED+3,0));
    wr(ca(1,0), lit(S_EXP+0,0));
    wr(ca(1,7), lit(S_DED+5,0));
    wr(ca(2,0), lit(S_EXP+1,0));
    wr(ca(3,0), lit(S_DED+6,0));
    wr(ca(3,6), lit(S_IC+1,0));
    wr(ca(3,5), lit(S_IC+2,0));
    wr(ca(3,4), lit(S_IC+3,0));
    wr(ca(4,0), lit(S_MC+3,0));
    wr(ca(5,0), lit(S_PIN+3,0));
    wr(ca(6,0), lit(S_PIN+1,0));
    wr(ca(7,0), lit(S_IC+4,0));
    wr(ca(7,3), lit(S_MC+7,0));
    wr(ca(8,0), lit(S_DED+7,0) | lit(S_DED+7,1));
    wr(ca(9,0), lit(S_DED+7,1));
    wr(NTRM, MW'(16'h0377));
    tick();

    // R1 R2 R4: vector table, exp0 shared by cells 0 and 1
    for (int v = 0; v < 8; v++) begin
      ded_i = {4'b0, VEC[v][6:3]};
      ic_i[0] = VEC[v][2];
      #1;
      chk("R4 R2 table pad_o[1:0]", 32'(pad_o[1:0]), 32'(VEC[v][1:0]));
    end

    // R7: enable term
    ded_i = 8'h20; #1;
    chk("R7 pad_oe[1] on", 32'(pad_oe[1]), 1);
    chk("R7 pad_oe[0] empty term off", 32'(pad_oe[0]), 0);

    // R3 chain exp0 -> exp1
    ded_i = 8'h14; ic_i[0] = 1'b1; #1;
    chk("R3 chain d2=1", 32'(pad_o[2]), 1);
    ded_i = 8'h10; #1;
    chk("R3 chain d2=0 d4=1", 32'(pad_o[2]), 0);
    ded_i = 8'h00; #1;
    chk("R3 chain d4=0", 32'(pad_o[2]), 1);

    // R1: contradictory and inverted literals
    chk("R1 both polarities false", 32'(pad_o[8]), 0);
    chk("R1 low literal d7=0", 32'(pad_o[9]), 1);
    ded_i[7] = 1'b1; #1;
    chk("R1 low literal d7=1", 32'(pad_o[9]), 0);
    ded_i[7] = 1'b0;

    // R8: driven pad fed back, external level ignored
    ded_i = 8'h20; ic_i[0] = 1'b0; pad_i[1] = 1'b0;
    tick();
    chk("R8 driven pad level", 32'(pad_o[6]), 1);
    ded_i = 8'h00; pad_i[1] = 1'b0;
    tick();
    chk("R8 undriven pad low", 32'(pad_o[6]), 0);
    pad_i[3] = 1'b1; #1;
    chk("R8 before edge", 32'(pad_o[5]), 0);
    tick();
    chk("R8 after edge", 32'(pad_o[5]), 1);

    // R5 R6 R9: register of cell 3, pad 3 used as input
    ded_i[6] = 1'b1; ic_i[1] = 1'b0;
    tick();
    chk("R5 hold with enable off", 32'(pad_o[3]), 0);
    ic_i[1] = 1'b1;
    tick();
    chk("R5 load with enable on", 32'(pad_o[3]), 1);
    chk("R9 buried feedback", 32'(pad_o[4]), 1);
    chk("R9 pad 3 undriven", 32'(pad_oe[3]), 0);
    ded_i[6] = 1'b0; ic_i[1] = 1'b0;
    tick();
    chk("R5 hold value 1", 32'(pad_o[3]), 1);
    ic_i[2] = 1'b1; ic_i[3] = 1'b1;
    tick();
    chk("R6 clear beats set", 32'(pad_o[3]), 0);
    ic_i[2] = 1'b0;
    tick();
    chk("R6 set forces 1", 32'(pad_o[3]), 1);
    ic_i[3] = 1'b0;

    // R4 R5: toggle cell 7 via polarity term on own feedback
    chk("R5 toggle start", 32'(pad_o[7]), 0);
    ic_i[4] = 1'b1;
    tick();
    chk("R5 toggle first", 32'(pad_o[7]), 1);
    tick();
    chk("R5 toggle second", 32'(pad_o[7]), 0);
    ic_i[4] = 1'b0;
    tick();
    chk("R5 toggle idle", 32'(pad_o[7]), 0);

    // R11: write above mode word ignored
    wr(NTRM + 20, '1);
    ded_i = 8'h10; ic_i[0] = 1'b0; #1;
    chk("R11 high address no error", 32'(cfg_err), 0);
    chk("R11 high address no change", 32'(pad_o[2]), 0);

    // R3: self reference refused
    wr(1, lit(S_EXP+1,0));
    chk("R3 loop flagged", 32'(cfg_err), 1);
    chk("R3 term kept", 32'(pad_o[2]), 0);
    ded_i = 8'h00; #1;
    chk("R3 term kept d4=0", 32'(pad_o[2]), 1);
    tick();
    chk("R3 flag sticky", 32'(cfg_err), 1);

    // R10: reset again clears everything
    rst_n = 1'b0; #1;
    chk("R10 reset clears error", 32'(cfg_err), 0);
    chk("R10 reset clears pads", 32'(pad_o), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule